// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

A single-port synchronous memory. Address, command and write data pass through input registers, and the read path has no output register. A command is captured on one rising clock edge. Its data transfer, read or write, takes place during the following clock cycle. The data bus carries the data of the previous command while the next command is being presented, so reads and writes can alternate on consecutive cycles with no idle bus cycle between them.

A clock enable freezes the whole block. Three chip enables of mixed polarity gate new commands. A load/advance select either loads a fresh address or steps a 4-beat burst counter, and the burst order is linear or interleaved. Active-low byte selects choose which 9-bit lanes a write updates. An output enable acts on the read data at once, without waiting for a clock. A sleep input blocks new commands and disables the output. The bidirectional data bus is modelled as a write-data input, a read-data output and an output-drive indication.

Top module: `zbt_sram`

## Requirements
- R1: The command presented at a rising edge with `cen_ni` low is performed in the cycle after that edge. For a read, `dout_o` shows the array word at the command's address during that cycle, with no output register in the path.
- R2: Reads and writes may follow each other on consecutive cycles. A write's data is taken from `din_i` on the edge that ends its data cycle and is committed on that edge. A read of the same address issued at that same edge returns the new word.
- R3: At an edge where `cen_ni` is high, every input is ignored and all state holds. An output being shown stays unchanged, and a pending write is held until the next enabled edge, where it takes that edge's `din_i`.
- R4: A load (`adv_i`=0) starts a new operation only when `ce_a_ni`=0, `ce_b_i`=1 and `ce_c_ni`=0. Any other combination deselects the block, and `dout_en_o` is 0 for the following cycle.
- R5: A write or read already issued still completes its data cycle when the next command deselects the block.
- R6: `dout_en_o` is 0 throughout the data cycle of a write.
- R7: `oe_ni` high forces `dout_en_o` to 0 at once, with no clock edge needed. Lowering it again restores the read data.
- R8: Lane i of the 36-bit word is bits [9i+8:9i]. A write updates lane i only when `bw_ni[i]` is 0.
- R9: An advance (`adv_i`=1) after an active operation repeats that operation's type on the next burst address. The burst index n counts 0,1,2,3 and then wraps. The low two address bits are (b+n) mod 4 in linear order (`burst_lin_i`=1 at the load) or b XOR n in interleaved order, where b is the loaded low two bits. The upper bits do not change. An advance while deselected keeps the block deselected.
- R10: An enabled edge with `sleep_i` high starts no operation. While `sleep_i` is high, `dout_en_o` is 0. Array contents are kept.
- R11: After reset no operation is pending and `dout_en_o` is 0.
- R12: `dout_o` is all zeros whenever `dout_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| ce_a_ni | input | 1 | Chip enable, active low |
| ce_b_i | input | 1 | Chip enable, active high |
| ce_c_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 1 advance burst, 0 load new address |
| rw_i | input | 1 | 1 read, 0 write (at load) |
| burst_lin_i | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr_i | input | AW | Word address |
| bw_ni | input | LANES | Byte-lane write selects, active low |
| din_i | input | LANES*LANE_W | Write data for the current data cycle |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| sleep_i | input | 1 | Sleep: block commands, disable output |
| dout_o | output | LANES*LANE_W | Read data, flow-through |
| dout_en_o | output | 1 | Read data is being driven |

## Verification
The assertions check on every cycle that a disabled clock freezes the command state, that a deselecting load or a sleeping edge leaves no operation pending, that each burst advance steps the index by one with the operation type unchanged, and that the output stays off during write cycles, under `oe_ni` and under sleep. Data correctness can only be shown by the bench scenarios. These include a full write and read sweep, byte-lane patterns, write-then-read of one address on back-to-back edges, bursts from every start offset in both orders with wraparound, a pending write completed across a deselect, a write deferred over a stalled edge, and contents kept through sleep.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;

  // low two burst address bits for start offset b and beat n
  function automatic logic [1:0] burst_lo(input logic [1:0] b, input logic [1:0] n,
                                          input logic lin);
    return lin ? 2'(b + n) : (b ^ n);
  endfunction
endpackage

// File: rtl/zbt_burst_ctr.sv
module zbt_burst_ctr #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    beat_i,
  input  logic          lin_i,
  output logic [AW-1:0] addr_o
);
  import zbt_pkg::*;

  generate
    if (AW > 2) begin : g_wide
      assign addr_o = {base_i[AW-1:2], burst_lo(base_i[1:0], beat_i, lin_i)};
    end else begin : g_narrow
      logic [1:0] lo;
      assign lo     = burst_lo(2'(base_i), beat_i, lin_i);
      assign addr_o = lo[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/zbt_cmd_reg.sv
module zbt_cmd_reg #(
  parameter int AW = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cen_ni,
  input  logic            ce_ok_i,
  input  logic            sleep_i,
  input  logic            adv_i,
  input  logic            rw_i,
  input  logic            lin_i,
  input  logic [AW-1:0]   addr_i,
  output logic            valid_o,
  output zbt_pkg::op_e    op_o,
  output logic            lin_o,
  output logic [AW-1:0]   base_o,
  output logic [1:0]      beat_o
);
  import zbt_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      op_o    <= OP_WRITE;
      lin_o   <= 1'b0;
      base_o  <= '0;
      beat_o  <= '0;
    end else if (!cen_ni) begin
      if (sleep_i) begin
        valid_o <= 1'b0;
      end else if (!adv_i) begin
        valid_o <= ce_ok_i;
        if (ce_ok_i) begin
          op_o   <= rw_i ? OP_READ : OP_WRITE;
          lin_o  <= lin_i;
          base_o <= addr_i;
          beat_o <= '0;
        end
      end else if (valid_o) begin
        beat_o <= beat_o + 2'd1;  // op type and base repeat
      end
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> $stable({valid_o, op_o, lin_o, base_o, beat_o})); // R3
  AST_DESEL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !adv_i && !ce_ok_i) |=> !valid_o); // R4
  AST_SLEEP_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && sleep_i) |=> !valid_o); // R10
  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !sleep_i && adv_i && valid_o) |=>
      (valid_o && beat_o == 2'($past(beat_o) + 2'd1) && $stable(op_o) && $stable(base_o))); // R9
  AST_LOAD_BEAT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !sleep_i && !adv_i && ce_ok_i) |=> (valid_o && beat_o == 2'd0)); // R9
endmodule

// File: rtl/zbt_lane_ram.sv
module zbt_lane_ram #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_ni,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && !bw_ni[l]) mem[addr_i] <= din_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];  // flow-through
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_ni,
  input  logic             ce_a_ni,
  input  logic             ce_b_i,
  input  logic             ce_c_ni,
  input  logic             adv_i,
  input  logic             rw_i,
  input  logic             burst_lin_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_ni,
  input  logic [DW-1:0]    din_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  output logic [DW-1:0]    dout_o,
  output logic             dout_en_o
);
  import zbt_pkg::*;

  logic          ce_ok;
  logic          valid;
  op_e           op;
  logic          lin;
  logic [AW-1:0] base;
  logic [1:0]    beat;
  logic [AW-1:0] cur_addr;
  logic          we;
  logic [DW-1:0] rdata;

  assign ce_ok = !ce_a_ni && ce_b_i && !ce_c_ni;

  zbt_cmd_reg #(.AW(AW)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cen_ni  (cen_ni),
    .ce_ok_i (ce_ok),
    .sleep_i (sleep_i),
    .adv_i   (adv_i),
    .rw_i    (rw_i),
    .lin_i   (burst_lin_i),
    .addr_i  (addr_i),
    .valid_o (valid),
    .op_o    (op),
    .lin_o   (lin),
    .base_o  (base),
    .beat_o  (beat)
  );

  zbt_burst_ctr #(.AW(AW)) u_burst (
    .base_i (base),
    .beat_i (beat),
    .lin_i  (lin),
    .addr_o (cur_addr)
  );

  // write commits on the edge that closes its data cycle
  assign we = !cen_ni && valid && (op == OP_WRITE);

  zbt_lane_ram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (we),
    .addr_i  (cur_addr),
    .bw_ni   (bw_ni),
    .din_i   (din_i),
    .rdata_o (rdata)
  );

  assign dout_en_o = valid && (op == OP_READ) && !oe_ni && !sleep_i;
  assign dout_o    = dout_en_o ? rdata : '0;

  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && op == OP_WRITE) |-> !dout_en_o); // R6
  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!dout_en_o && dout_o == '0)); // R7
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dout_en_o); // R10
  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_en_o |-> dout_o == '0); // R12
endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;
  localparam int AW = 10, LANES = 4, LANE_W = 9, DW = 36, DEPTH = 1 << AW;
  localparam logic [2:0] CE_GOOD = 3'b010;  // {ce_a_ni, ce_b_i, ce_c_ni}

  logic clk = 0, rst_ni = 0;
  logic cen_ni = 1, ce_a_ni = 1, ce_b_i = 0, ce_c_ni = 1, adv_i = 0, rw_i = 0;
  logic burst_lin_i = 0, oe_ni = 0, sleep_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [LANES-1:0] bw_ni = '1;
  logic [DW-1:0] din_i = '0, dout_o;
  logic dout_en_o;

  always #2.5 clk = ~clk;

  zbt_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cen_ni(cen_ni), .ce_a_ni(ce_a_ni), .ce_b_i(ce_b_i),
    .ce_c_ni(ce_c_ni), .adv_i(adv_i), .rw_i(rw_i), .burst_lin_i(burst_lin_i),
    .addr_i(addr_i), .bw_ni(bw_ni), .din_i(din_i), .oe_ni(oe_ni), .sleep_i(sleep_i),
    .dout_o(dout_o), .dout_en_o(dout_en_o));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R11";
  logic [DW-1:0] mdl [DEPTH];
  bit m_valid = 0, m_rd = 0, m_lin = 0;
  int m_base = 0, m_beat = 0;
  logic [DW-1:0] pend_d = '0;
  logic [LANES-1:0] pend_bw = '1;

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(64'(a) * 64'h9E3779B1 + 64'(k) * 64'h2545F491) ^ 36'h5A5A5A5A5;
  endfunction

  function automatic int m_addr();
    int lo = m_lin ? ((m_base + m_beat) % 4) : ((m_base % 4) ^ m_beat);
    return (m_base & ~3) | lo;
  endfunction

  task automatic check(input string req, input bit exp_en, input logic [DW-1:0] exp_d);
    n_chk++;
    if (dout_en_o !== exp_en || dout_o !== exp_d) begin
      n_fail++;
      $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h", req, dout_en_o, dout_o,
               exp_en, exp_d);
    end
  endtask

  task automatic expect_now(input string req);
    bit e = m_valid && m_rd && !oe_ni && !sleep_i;
    check(req, e, e ? mdl[m_addr()] : '0);  // R12: zeros when disabled
  endtask

  // one clock: drive at negedge, model the edge, sample 1 ns after it
  task automatic step(input bit cen_n, input logic [2:0] ce, input bit rw, input bit adv,
                      input int addr, input logic [LANES-1:0] bw_new,
                      input logic [DW-1:0] d_new, input bit slp);
    @(negedge clk);
    cen_ni = cen_n; {ce_a_ni, ce_b_i, ce_c_ni} = ce; rw_i = rw; adv_i = adv;
    addr_i = AW'(addr); sleep_i = slp;
    din_i = cen_n ? ~pend_d : pend_d;   // garbage on stalled edges
    bw_ni = cen_n ? ~pend_bw : pend_bw;
    @(posedge clk);
    if (!cen_n) begin
      if (m_valid && !m_rd)
        for (int l = 0; l < LANES; l++)
          if (!pend_bw[l]) mdl[m_addr()][l*LANE_W +: LANE_W] = pend_d[l*LANE_W +: LANE_W];
      if (slp) m_valid = 0;
      else if (!adv) begin
        m_valid = (ce == CE_GOOD);
        if (m_valid) begin m_rd = rw; m_base = addr; m_beat = 0; m_lin = burst_lin_i; end
      end else if (m_valid) m_beat = (m_beat + 1) % 4;
      pend_d = d_new; pend_bw = bw_new;
    end
    #1;
    expect_now(cur_req);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [LANES-1:0] bw = '0);
    step(0, CE_GOOD, 0, 0, a, bw, d, 0);
  endtask
  task automatic rd(input int a);
    step(0, CE_GOOD, 1, 0, a, '1, '0, 0);
  endtask
  task automatic adv(input logic [DW-1:0] d = '0);
    step(0, CE_GOOD, 0, 1, 0, '0, d, 0);
  endtask
  task automatic desel(input logic [2:0] ce = 3'b111);
    step(0, ce, 0, 0, 0, '1, '0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    #12;
    #1 check("R11", 0, '0);
    rst_ni = 1;
    desel();
    check("R11", 0, '0);

    // R1 R2: full sweep, then back-to-back read/write
    cur_req = "R1";
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 0));
    for (int a = 0; a < DEPTH; a++) rd(a);
    cur_req = "R2";
    for (int a = 0; a < 64; a++) begin
      wr(a * 7 % DEPTH, pat(a, 1));
      rd(a * 7 % DEPTH);
      rd((a * 7 + 1) % DEPTH);
    end
    cur_req = "R6";
    for (int a = 0; a < 8; a++) wr(a, pat(a, 2));
    rd(3);

    // R8: every lane select pattern
    cur_req = "R8";
    for (int b = 0; b < 16; b++) begin
      wr(100 + b, pat(b, 3), 4'(b));
      rd(100 + b);
    end

    // R9: bursts from every offset in both orders, five beats to wrap
    cur_req = "R9";
    for (int lin = 0; lin < 2; lin++)
      for (int b = 0; b < 4; b++) begin
        @(negedge clk) burst_lin_i = lin[0];
        rd(200 + b);
        for (int k = 0; k < 4; k++) adv();
        wr(300 + b, pat(b, 4 + lin));
        for (int k = 0; k < 3; k++) adv(pat(b + k, 6 + lin));
        rd(300);
        for (int k = 0; k < 3; k++) adv();
      end
    desel();
    adv();       // advance while deselected stays deselected
    adv();

    // R4: every non-matching chip enable combination
    cur_req = "R4";
    for (int c = 0; c < 8; c++)
      if (3'(c) != CE_GOOD) begin
        rd(5);
        desel(3'(c));
        rd(5);
        step(0, 3'(c), 1, 0, 9, '1, '0, 0);
      end

    // R5: pending write and read finish across a deselect
    cur_req = "R5";
    wr(400, pat(400, 9));
    desel();
    rd(400);
    desel();
    desel();

    // R3: stalled edges hold output and defer a pending write
    cur_req = "R3";
    rd(401);
    step(1, CE_GOOD, 0, 0, 17, '0, '0, 0);
    step(1, 3'b111, 0, 1, 18, '0, '0, 0);
    wr(402, pat(402, 10));
    step(1, CE_GOOD, 1, 0, 3, '1, '0, 0);
    rd(402);
    desel();

    // R7: output enable acts between edges
    cur_req = "R7";
    rd(50);
    #0.5 oe_ni = 1;
    #0.3 check("R7", 0, '0);
    #0.3 oe_ni = 0;
    #0.3 check("R7", 1, mdl[50]);
    step(0, CE_GOOD, 1, 0, 51, '1, '0, 0);

    // R10: sleep blocks commands, gates output, keeps contents
    cur_req = "R10";
    wr(500, pat(500, 11));
    step(0, CE_GOOD, 1, 0, 500, '1, '0, 1);
    step(0, CE_GOOD, 1, 0, 500, '1, '0, 1);
    rd(500);
    #0.5 sleep_i = 1;
    #0.3 check("R10", 0, '0);
    #0.3 sleep_i = 0;
    #0.3 check("R10", 1, mdl[500]);
    for (int a = 0; a < 8; a++) rd(a);
    desel();

    finish_run();
  end
endmodule